// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block makes a system-clocked design answer on a two-wire serial bus as a small 128 x 8 byte memory. It oversamples the bus clock and data lines with the system clock. It finds start and stop conditions and moves bytes most significant bit first. It pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero. The pad, the pull-up and any real nonvolatile cell lie outside the block. The contents are plain flops that clear at reset.

A transaction starts with one byte that holds a 7-bit word address in its upper bits and a direction bit in bit 0. The direction bit is 1 for a read. A write sends up to four data bytes into a page buffer, and the stop that ends it copies the whole page into the array at once. A programmable busy interval then follows, during which the slave does not react to the bus. A read returns bytes from the supplied address onward for as long as the master acknowledges them. A standby output shows when the slave is at rest. That is after reset, or after a stop once any write interval has run out.

Top module: `ser_eeprom_slave`

## Requirements
- R1: After reset the data-line pull-down is off, the standby output is high and every byte of the array reads as 0x00.
- R2: The pull-down enable changes only while the sampled bus clock is low.
- R3: A start (data falling while the bus clock is high) taken outside a write interval drops standby. A stop (data rising while the clock is high) with no write to commit brings standby back.
- R4: The first byte after a start is {word address[6:0], direction}, direction 1 = read. The slave acknowledges it by pulling the data line low during the ninth clock.
- R5: In a write, every data byte is acknowledged and stored at the current address. Only address bits [1:0] advance, wrapping within the 4-byte page while bits [6:2] stay fixed. A fifth byte therefore overwrites the first.
- R6: A stop after at least one data byte writes the buffered bytes to the array and starts a busy interval of BUSY_CYCLES clocks. Standby rises 3 clocks after the line change plus BUSY_CYCLES. A write with no data bytes starts no interval.
- R7: During the busy interval a start is ignored, the address byte is not acknowledged and the pull-down stays off.
- R8: A read sends the byte at the supplied address, MSB first. Each master acknowledge moves the address up by one, wrapping from 0x7F to 0x00, and sends the next byte.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and stays out of standby until a stop.
- R10: A repeated start before the stop throws away any page bytes buffered in that write, so nothing is written and no busy interval follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_low_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| standby_o | output | 1 | 1 = idle with no write interval running |

## Verification
The bus inputs reach the control logic through two synchronizer flops and one edge-detect flop. A line change therefore shows up in the state three clocks later. The bench drives every bus phase for 8 system clocks and reads the data line in the middle of each high phase, well after the slave has settled. The standby checks after a stop wait 16 clocks. The busy interval is measured from the stop edge with a clock counter, and a window of one clock either side of BUSY_CYCLES+3 is accepted. The behavioural model keeps a byte array and a page cursor, and predicts every acknowledge bit and read byte on its own.

// File: rtl/eep_pkg.sv
// Shared types for the two-wire memory slave.
package eep_pkg;
    // Protocol phases of the slave.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_WAIT_STOP
    } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
// Synchronizes the bus clock and data lines and flags their events.
// Assumes both lines are asynchronous to clk and held for several clocks.
// Outputs are valid SYNC_STAGES+1 clocks after a line change.
module eep_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_prev, sda_prev;

    // Synchronizer chains; the idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
    end

    // Previous synchronized levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_ff[SYNC_STAGES-1];
    assign sda_lvl   = sda_ff[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: one byte lane per page position, each with a valid flag.
// Clear wins over load; a load into a valid lane overwrites it.
module eep_page_buf #(
    parameter int LANES  = 4,
    parameter int DATA_W = 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         load,
    input  logic [LANE_W-1:0]            lane,
    input  logic [DATA_W-1:0]            din,
    output logic [LANES-1:0][DATA_W-1:0] data,
    output logic [LANES-1:0]             valid
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] byte_q;
        logic              vld_q;

        // Holds one page byte until commit or clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (load && lane == LANE_W'(g)) begin
                byte_q <= din;
                vld_q  <= 1'b1;
            end
        end

        assign data[g]  = byte_q;
        assign valid[g] = vld_q;
    end
endmodule

// File: rtl/eep_store.sv
// Byte array with a page-wide write port and an asynchronous read port.
// Stands in for the nonvolatile cells; cleared at reset.
module eep_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int LANES  = 4,
    localparam int WORDS  = 1 << ADDR_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int BASE_W = ADDR_W - LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [BASE_W-1:0]            wr_base,
    input  logic [LANES-1:0]             wr_mask,
    input  logic [LANES-1:0][DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DATA_W-1:0] mem [WORDS];

    // Writes every masked lane of the selected page in one clock.
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (wr_en && wr_mask[w % LANES]
                         && wr_base == BASE_W'(w / LANES)) begin
                mem[w] <= wr_data[w % LANES];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_busy_timer.sv
// Down-counter that models the self-timed write interval.
module eep_busy_timer #(
    parameter int BUSY_CYCLES = 1_000_000,
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    // Loads the interval on start, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(BUSY_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/ser_eeprom_slave.sv
// Two-wire serial memory slave: protocol control, address counter,
// page buffer commit and busy gating.
// Assumes the first byte is ADDR_W address bits plus one direction bit,
// so DATA_W == ADDR_W + 1, and that bus phases last several clocks.
module ser_eeprom_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_low_o,
    output logic standby_o
);
    localparam int LANE_W = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - LANE_W;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    eep_state_e              state;
    logic [BIT_W-1:0]        bitcnt;
    logic [DATA_W-1:0]       shreg;
    logic                    byte_done;
    logic [ADDR_W-1:0]       addr;
    logic                    rd_dir;
    logic                    mack;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                    busy, commit, buf_clr, buf_load, wr_phase;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] pg_data;
    logic [PAGE_BYTES-1:0]   pg_valid;
    logic [DATA_W-1:0]       rd_data;

    eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    eep_page_buf #(.LANES(PAGE_BYTES), .DATA_W(DATA_W)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .load(buf_load),
        .lane(addr[LANE_W-1:0]), .din(shreg),
        .data(pg_data), .valid(pg_valid)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(commit),
        .wr_base(addr[ADDR_W-1:LANE_W]), .wr_mask(pg_valid), .wr_data(pg_data),
        .rd_addr(addr), .rd_data(rd_data)
    );

    eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
    );

    // Buffer control: any bus condition empties it, a stop commits it first.
    assign commit   = stop_det && (|pg_valid);
    assign buf_clr  = start_det || stop_det;
    assign buf_load = (state == ST_WDATA) && scl_fall && byte_done
                      && !start_det && !stop_det;
    assign wr_phase = (state == ST_WDATA) || (state == ST_WDATA_ACK);

    // Protocol sequencer, advanced on synchronized bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            addr      <= '0;
            rd_dir    <= 1'b0;
            mack      <= 1'b0;
        end else if (start_det) begin
            if (!busy) begin
                state     <= ST_ADDR;
                bitcnt    <= '0;
                byte_done <= 1'b0;
            end
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) byte_done <= 1'b1;
                    end else if (scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        if (state == ST_ADDR) begin
                            addr   <= shreg[DATA_W-1:1];
                            rd_dir <= shreg[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            addr[LANE_W-1:0] <= addr[LANE_W-1:0] + 1'b1;
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    state  <= rd_dir ? ST_RDATA : ST_WDATA;
                end
                ST_WDATA_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    state  <= ST_WDATA;
                end
                ST_RDATA: if (scl_fall) begin
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) state <= ST_RDATA_ACK;
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) mack <= ~sda_lvl;
                    else if (scl_fall) begin
                        if (mack) begin
                            addr   <= addr + 1'b1;
                            bitcnt <= '0;
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_WAIT_STOP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Open-drain enable: acknowledge slots and zero bits of read data.
    always_comb begin
        case (state)
            ST_ADDR_ACK, ST_WDATA_ACK: sda_low_o = 1'b1;
            ST_RDATA:                  sda_low_o = ~rd_data[LAST_BIT - bitcnt];
            default:                   sda_low_o = 1'b0;
        endcase
    end

    assign standby_o = (state == ST_IDLE) && !busy;
endmodule

// File: rtl/eep_checker.sv
// Protocol properties of the serial memory slave, bound to its top.
module eep_checker #(
    parameter int HI_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_lvl,
    input logic            sda_low,
    input logic            standby,
    input logic            busy,
    input logic            start_det,
    input logic            stop_det,
    input logic            wr_phase,
    input logic [HI_W-1:0] page_hi
);
    p_sda_moves_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_lvl);

    p_start_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !busy) |=> !standby);

    p_page_hi_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && $past(wr_phase)) |-> $stable(page_hi));

    p_busy_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_low);
endmodule

bind ser_eeprom_slave eep_checker #(.HI_W(BASE_W)) u_eep_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_low(sda_low_o),
    .standby(standby_o), .busy(busy), .start_det(start_det),
    .stop_det(stop_det), .wr_phase(wr_phase),
    .page_hi(addr[ADDR_W-1:LANE_W])
);

// File: tb/test_ser_eeprom_slave.sv
`timescale 1ns/1ps
module test_ser_eeprom_slave;
    localparam int Q    = 8;
    localparam int BUSY = 2000;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_low, standby, sda_line;
    int   n_chk = 0, n_fail = 0, r2_err = 0;
    bit   done = 1'b0;
    logic [7:0] ref_mem [128];

    assign sda_line = sda_m & ~sda_low;
    always #2.5 clk = ~clk;

    ser_eeprom_slave #(.BUSY_CYCLES(BUSY)) i_ser_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_low_o(sda_low), .standby_o(standby)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    // One bus clock; samples the wired line mid-high, R2 stability check.
    task automatic bit_cycle(input logic v, output logic s);
        logic held;
        sda_m = v; wq();
        scl_m = 1'b1; wq();
        s = sda_line; held = sda_low;
        wq();
        if (sda_low !== held) r2_err++;
        scl_m = 1'b0; wq();
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b1, s);
            b = {b[6:0], s};
        end
        bit_cycle(~give_ack, s);
    endtask

    task automatic wait_standby();
        int guard = 0;
        while (!standby && guard < 3 * BUSY) begin
            @(negedge clk); guard++;
        end
    endtask

    // Model update: bytes land in the page at a wrapping 2-bit cursor.
    task automatic model_page(input logic [6:0] a, input logic [7:0] d[$]);
        logic [1:0] lane = a[1:0];
        foreach (d[k]) begin
            ref_mem[{a[6:2], lane}] = d[k];
            lane = lane + 2'd1;
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d[$], input bit settle);
        logic ack;
        start_c();
        send_byte({a, 1'b0}, ack);
        check("R4 write address ack", ack, 1);
        foreach (d[k]) begin
            send_byte(d[k], ack);
            check("R5 data byte ack", ack, 1);
        end
        stop_c();
        model_page(a, d);
        if (d.size() > 0) check("R6 busy after commit", standby, 0);
        else              check("R6 no busy without data", standby, 1);
        if (settle) wait_standby();
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] b;
        start_c();
        check("R3 start leaves standby", standby, 0);
        send_byte({a, 1'b1}, ack);
        check("R4 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            check(tag, b, ref_mem[7'(int'(a) + k)]);
        end
        check("R9 released after master nack", sda_low, 0);
        check("R9 no standby before stop", standby, 0);
        stop_c();
        check("R3 stop restores standby", standby, 1);
    endtask

    initial begin
        repeat (LIMIT_CYCLES()) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic int LIMIT_CYCLES();
        return 190000;
    endfunction

    initial begin
        logic ack;
        logic [7:0] b;
        logic [7:0] q[$];
        int cnt;
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 pull-down off after reset", sda_low, 0);
        check("R1 standby after reset", standby, 1);
        do_read(7'h05, 1, "R1 array clear after reset");

        // Timed single-byte write to 0x10.
        start_c();
        send_byte({7'h10, 1'b0}, ack); check("R4 write address ack", ack, 1);
        send_byte(8'hA5, ack);         check("R5 data byte ack", ack, 1);
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b1; cnt = 0;
        while (!standby && cnt < 3 * BUSY) begin @(negedge clk); cnt++; end
        ref_mem[7'h10] = 8'hA5;
        check("R6 busy interval length", (cnt >= BUSY + 2 && cnt <= BUSY + 4), 1);

        // Write to 0x11, then probe during busy.
        q = {8'h5A};
        do_write(7'h11, q, 1'b0);
        start_c();
        check("R7 start ignored while busy", standby, 0);
        send_byte({7'h11, 1'b1}, ack);
        check("R7 no ack while busy", ack, 0);
        stop_c();
        wait_standby();
        check("R6 standby after interval", standby, 1);
        do_read(7'h10, 2, "R8 sequential read");

        // Page write starting mid-page wraps the cursor.
        q = {8'h01, 8'h02, 8'h03, 8'h04};
        do_write(7'h22, q, 1'b1);
        do_read(7'h20, 6, "R5 page wrap readback");

        // Five bytes: the fifth overwrites the first.
        q = {8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
        do_write(7'h40, q, 1'b1);
        do_read(7'h40, 4, "R5 fifth byte overwrite");

        // Address-only write.
        q = {};
        do_write(7'h60, q, 1'b1);

        // Repeated start abandons buffered bytes.
        start_c();
        send_byte({7'h50, 1'b0}, ack); check("R4 write address ack", ack, 1);
        send_byte(8'h77, ack);         check("R5 data byte ack", ack, 1);
        start_c();
        send_byte({7'h50, 1'b1}, ack); check("R10 read after restart ack", ack, 1);
        recv_byte(1'b0, b);
        check("R10 abandoned byte not written", b, 8'h00);
        stop_c();
        check("R10 no busy after abandon", standby, 1);

        // Address wrap on sequential read.
        q = {8'h3C};
        do_write(7'h7F, q, 1'b1);
        q = {8'h11};
        do_write(7'h00, q, 1'b1);
        do_read(7'h7F, 2, "R8 read address wrap");

        check("R2 pull-down stable while clock high", r2_err, 0);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule